// File: doc/BRIEF.md
# Replicated Multi-Read-Port RAM

This block is a synchronous memory that serves several independent read ports and a single write port in every clock cycle. Each read port owns a private copy of the whole storage array. A write is decoded once and applied to every copy on the same clock edge, so all copies always hold identical contents. Each read port addresses only its own copy, so every port can read any location in the same cycle without arbitration or stalls.

Read results are registered. A port's output register loads on a rising edge at which that port's read enable is high. It keeps its value while the enable is low. When a read and the write hit the same location on the same edge, the read returns the contents from before the write, and every port behaves this way.

The memory depth, the data width and the number of read ports are parameters. The number of read ports is at least one.

Top module: `repl_read_ram`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, every read data output is all zeros.
- R2: A single write with `wr_en` high updates the addressed word in all copies on the same edge, so a read of that word on any port at a later edge returns the written data.
- R3: All read ports may address different locations, or the same location, in the same cycle, and each port returns the contents of its own address.
- R4: Port p's read data (bits `p*DATA_W` upward in `rd_data`, address in bits `p*ADDR_W` upward in `rd_addr`) becomes valid one clock edge after the edge at which `rd_en[p]` is sampled high.
- R5: While `rd_en[p]` is low, port p's read data holds its previous value.
- R6: When a read on any port and the write target the same address on the same edge, that read returns the word's contents from before the write.
- R7: With `wr_en` low, the values on `wr_addr` and `wr_data` change no stored word.
- R8: A write changes only the addressed word. All other words keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the read data registers |
| wr_en | input | 1 | Write enable, shared by all copies |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | N_RD | Read enable, one bit per port |
| rd_addr | input | N_RD*ADDR_W | Packed read addresses, port p in bits p*ADDR_W upward |
| rd_data | output | N_RD*DATA_W | Packed registered read data, port p in bits p*DATA_W upward |

## Verification
The bench uses the default values: a depth of 16, a data width of 8 and three read ports. With only 16 words, random addresses on three ports often collide with each other and with the write address. This exercises read-before-write and same-address reads on all ports in the same cycle without any special steering. Three ports are enough to show that every copy agrees with the other two, and that any one port can hold its value while its neighbours read.

// File: rtl/rmr_pkg.sv
package rmr_pkg;

  // True when a write is active and targets word index idx.
  function automatic logic word_strobe(input logic en, input int unsigned addr,
                                       input int unsigned idx);
    return en && (addr == idx);
  endfunction

  // Bit offset of port p inside a packed per-port bus.
  function automatic int unsigned lane_lsb(input int unsigned p, input int unsigned w);
    return p * w;
  endfunction

endpackage

// File: rtl/rmr_wr_bcast.sv
module rmr_wr_bcast #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [DEPTH-1:0]  word_we
);

  for (genvar w = 0; w < DEPTH; w++) begin : g_strobe
    assign word_we[w] = rmr_pkg::word_strobe(wr_en, int'(wr_addr), w);
  end

  // At most one word is written per edge.
  assert_single_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_we));

  // An enabled write always reaches its own word.
  assert_write_reaches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> word_we[wr_addr]);

  // With the write disabled, no word is touched.
  assert_idle_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (word_we == '0));

endmodule

// File: rtl/rmr_copy.sv
module rmr_copy #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEPTH-1:0]  word_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              rbw_hit;   // read and write on the same word this edge
  logic [DATA_W-1:0] cur_word;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (word_we[w]) mem[w] <= wr_data;
    end
  end

  assign cur_word = mem[rd_addr];
  assign rbw_hit  = rd_en && word_we[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= cur_word;
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));

  assert_old_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rbw_hit && (wr_data != cur_word)) |=> (rd_q != $past(wr_data)));

endmodule

// File: rtl/repl_read_ram.sv
module repl_read_ram #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int N_RD   = 3,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [N_RD-1:0]          rd_en,
  input  logic [N_RD*ADDR_W-1:0]   rd_addr,
  output logic [N_RD*DATA_W-1:0]   rd_data
);

  logic [DEPTH-1:0] word_we;

  initial begin
    assert_ports_ok_R3: assert (N_RD >= 1);
  end

  rmr_wr_bcast #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bcast (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .word_we (word_we)
  );

  for (genvar p = 0; p < N_RD; p++) begin : g_port
    localparam int AL = rmr_pkg::lane_lsb(p, ADDR_W);
    localparam int DL = rmr_pkg::lane_lsb(p, DATA_W);

    rmr_copy #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_copy (
      .clk     (clk),
      .rst_n   (rst_n),
      .word_we (word_we),
      .wr_data (wr_data),
      .rd_en   (rd_en[p]),
      .rd_addr (rd_addr[AL +: ADDR_W]),
      .rd_q    (rd_data[DL +: DATA_W])
    );

    if (p > 0) begin : g_agree
      // Copies stay identical: same address read on two ports gives the same word.
      assert_copies_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en[0] && rd_en[p] && (rd_addr[0 +: ADDR_W] == rd_addr[AL +: ADDR_W]))
        |=> (rd_data[0 +: DATA_W] == rd_data[DL +: DATA_W]));
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == '0));

endmodule

// File: tb/tb_repl_read_ram.sv
`timescale 1ns/1ps
module tb_repl_read_ram;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int NRD   = 3;
  localparam int AW    = 4;

  logic                clk = 0;
  logic                rst_n = 0;
  logic                wr_en = 0;
  logic [AW-1:0]       wr_addr = '0;
  logic [DW-1:0]       wr_data = '0;
  logic [NRD-1:0]      rd_en = '0;
  logic [NRD*AW-1:0]   rd_addr = '0;
  logic [NRD*DW-1:0]   rd_data;

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_q   [NRD];

  always #2.5 clk = ~clk;

  repl_read_ram #(.DEPTH(DEPTH), .DATA_W(DW), .N_RD(NRD)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] port_out(input logic [NRD*DW-1:0] bus, input int p);
    return bus[p*DW +: DW];
  endfunction

  task automatic check(input string tag, input int p, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s port %0d: actual=%h expected=%h", tag, p, act, exp);
    end
  endtask

  // Drive one cycle at the negedge, predict, clock, check at the next negedge.
  task automatic step(input string tag, input logic we, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wd, input logic [NRD-1:0] re,
                      input logic [NRD*AW-1:0] ra);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    for (int p = 0; p < NRD; p++)
      if (re[p]) exp_q[p] = ref_mem[ra[p*AW +: AW]];   // old contents
    if (we) ref_mem[wa] = wd;
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NRD; p++) check(tag, p, port_out(rd_data, p), exp_q[p]);
  endtask

  function automatic logic [NRD*AW-1:0] same_addr(input logic [AW-1:0] a);
    logic [NRD*AW-1:0] r;
    for (int p = 0; p < NRD; p++) r[p*AW +: AW] = a;
    return r;
  endfunction

  initial begin
    #(5 * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < NRD; p++) exp_q[p] = '0;
    rd_en = '1;
    repeat (3) @(negedge clk);
    for (int p = 0; p < NRD; p++) check("R1 in reset", p, port_out(rd_data, p), '0);
    rst_n = 1;
    rd_en = '0;
    @(negedge clk);
    for (int p = 0; p < NRD; p++) check("R1 after release", p, port_out(rd_data, p), '0);

    // Fill every word (R2).
    for (int a = 0; a < DEPTH; a++)
      step("R2 fill", 1'b1, AW'(a), DW'(8'h30 + a), '0, '0);
    // Read the same word on every port (R2, R3).
    step("R2 all ports same", 1'b0, '0, '0, '1, same_addr(4'd5));
    // Distinct addresses per port (R3, R4).
    step("R3 distinct", 1'b0, '0, '0, '1, {4'd9, 4'd2, 4'd15});
    // Hold with enables low while the write changes one read word (R5).
    step("R5 hold", 1'b1, 4'd2, 8'hA5, '0, {4'd0, 4'd0, 4'd0});
    step("R5 hold partial", 1'b0, '0, '0, 3'b010, {4'd0, 4'd2, 4'd0});
    // Collision on all ports: old data returned (R6), then new data visible (R2).
    step("R6 read-before-write", 1'b1, 4'd7, 8'hC3, '1, same_addr(4'd7));
    step("R2 new data", 1'b0, '0, '0, '1, same_addr(4'd7));
    // Write disabled: address and data ignored (R7).
    step("R7 idle write", 1'b0, 4'd11, 8'hFF, '0, '0);
    step("R7 readback", 1'b0, '0, '0, '1, same_addr(4'd11));
    // Neighbours untouched (R8).
    step("R8 write", 1'b1, 4'd12, 8'h5A, '0, '0);
    step("R8 neighbours", 1'b0, '0, '0, '1, {4'd13, 4'd12, 4'd11});

    // Constrained random traffic with frequent collisions (R4, R6).
    for (int i = 0; i < 400; i++) begin
      logic [NRD*AW-1:0] ra;
      logic [AW-1:0] wa;
      wa = AW'($urandom_range(0, DEPTH - 1));
      for (int p = 0; p < NRD; p++)
        ra[p*AW +: AW] = ($urandom_range(0, 3) == 0) ? wa : AW'($urandom_range(0, DEPTH - 1));
      step("R4 random", 1'($urandom_range(0, 1)), wa, DW'($urandom),
           NRD'($urandom), ra);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule